// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one unsigned N-bit operand by another. It does so one quotient bit per clock cycle, using the restoring method. A single working register holds the partial remainder in its upper part and collects quotient bits at its low end. The register is one bit wider than twice the operand width. That extra guard bit sits above the upper half and catches the carry when the partial remainder is doubled.

A one-cycle `start` pulse, taken while the unit is idle, does three things:
- it captures both operands;
- it loads the register with the dividend pre-shifted left by one place;
- it raises `busy`.

Each of the next N cycles tries to subtract the divisor from the upper part. If the subtraction borrows, the difference is dropped and a 0 is shifted in. Otherwise the difference is kept and a 1 is shifted in. One more cycle shifts the upper part right by one place to undo the last doubling. After that cycle the quotient sits in the low half and the remainder in the upper half. `done` pulses at that point, and the results stay on the outputs until the next accepted start.

A zero divisor needs no special path. The subtraction never borrows, so the quotient comes out as all ones and the remainder as the dividend. A flag, captured at start, reports this case.

Top module: `divu_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) busy, done, div_zero, quotient and remainder are all 0.
- R2: For a nonzero divisor, quotient equals floor(dividend / divisor) of the operands present at the accepted start.
- R3: For a nonzero divisor, remainder equals dividend mod divisor, and it is always smaller than the divisor.
- R4: A start is accepted at a rising edge where start is 1 and busy is 0. busy reads 1 from that edge onward. busy falls and done rises exactly N+1 edges after it.
- R5: done is high for exactly one cycle per operation, and never while busy is high.
- R6: A start pulse or an operand change while busy is high has no effect on the running operation's result or its timing.
- R7: A zero divisor gives div_zero=1 together with done, a quotient of all ones (2^N-1) and a remainder equal to the dividend. For a nonzero divisor, div_zero is 0.
- R8: While idle and without a new start, quotient, remainder and div_zero hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request, taken only while idle |
| dividend | input | N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| div_zero | output | 1 | Divisor was zero, valid from done onward |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |

## Verification
The bench builds the block with N=4. At that width all 256 dividend/divisor pairs can be run exhaustively. This covers every borrow pattern, the guard-bit case where the doubled remainder exceeds N bits, the zero divisor, and the all-ones operands. The same width keeps the N+1 edge latency short enough to count on every operation. It also allows start pulses and operand changes to be injected mid-operation and their lack of effect to be confirmed.

// File: rtl/divu_pkg.sv
// Package: shared types for the restoring divider.
// Assumes: nothing beyond the language itself.
package divu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } divu_state_e;
endpackage

// File: rtl/divu_ctrl.sv
// Control sequencer: accepts a start while idle, runs N step cycles, then one
// fix-up cycle, and pulses done.
// Assumes: start is sampled at rising edges; reset is synchronous, active low.
module divu_ctrl
    import divu_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    divu_state_e state_q;
    logic [CW-1:0] cnt_q;

    // Decode control strobes from the current state.
    always_comb begin
        busy = (state_q != ST_IDLE);
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        fix  = (state_q == ST_FIX);
    end

    // Advance the sequencer and count step cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4
    fix_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix |=> (done && !busy));
    // R6
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q != LAST) |=> step);
endmodule

// File: rtl/divu_datapath.sv
// Datapath: the (2N+1)-bit working register with a guard bit, the captured
// divisor and the zero flag; performs load, trial subtract/restore and fix-up.
// Assumes: load, step and fix are mutually exclusive strobes from the sequencer.
module divu_datapath #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         fix,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder,
    output logic         div_zero
);
    localparam int W = 2 * N + 1;

    logic [W-1:0] acc_q;
    logic [N-1:0] dvs_q;
    logic [N:0]   upper;
    logic [N+1:0] diff;
    logic         borrow;

    // Trial subtraction on the guarded upper part; the top bit is the borrow.
    always_comb begin
        upper  = acc_q[W-1:N];
        diff   = {1'b0, upper} - {2'b00, dvs_q};
        borrow = diff[N+1];
    end

    // Update the working register, divisor copy and zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            dvs_q    <= '0;
            div_zero <= 1'b0;
        end else if (load) begin
            acc_q    <= {{N{1'b0}}, dividend, 1'b0};
            dvs_q    <= divisor;
            div_zero <= (divisor == '0);
        end else if (step) begin
            if (borrow) acc_q <= {acc_q[W-2:0], 1'b0};
            else        acc_q <= {diff[N-1:0], acc_q[N-1:0], 1'b1};
        end else if (fix) begin
            acc_q <= {1'b0, acc_q[W-1:N+1], acc_q[N-1:0]};
        end
    end

    assign quotient  = acc_q[N-1:0];
    assign remainder = acc_q[W-2:N];

    // R3
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix |=> (div_zero || (remainder < dvs_q)));
    // R3
    guard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix |=> !acc_q[W-1]);
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step && !fix) |=> ($stable(acc_q) && $stable(div_zero)));
    // R7
    zero_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fix && div_zero) |=> (quotient == {N{1'b1}}));
endmodule

// File: rtl/divu_seq.sv
// Top: unsigned restoring sequential divider, one quotient bit per cycle,
// results valid N+1 edges after an accepted start.
// Assumes: operands stable only at the start edge; later changes are ignored.
module divu_seq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder
);
    logic load, step, fix;

    divu_ctrl #(.N(N)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fix   (fix),
        .busy  (busy),
        .done  (done)
    );

    divu_datapath #(.N(N)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .fix       (fix),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero)
    );

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: tb/divu_seq_tb.sv
module divu_seq_tb_top;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] dividend = '0;
    logic [N-1:0] divisor = '0;
    logic busy, done, div_zero;
    logic [N-1:0] quotient, remainder;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    divu_seq #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_zero(div_zero),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One division; if inject is set, a start and new operands are driven mid-run.
    task automatic run(input int a, input int b, input bit inject);
        int cycles;
        int eq, er;
        logic [N-1:0] hq, hr;
        @(negedge clk);
        dividend = N'(a);
        divisor  = N'(b);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (busy !== 1'b1) check("R4 busy after start", int'(busy), 1);
        cycles = 0;
        while (1) begin
            if (inject && cycles == 1) begin
                start = 1'b1;
                dividend = ~N'(a);
                divisor = N'(b + 1);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (done) break;
            if (busy !== 1'b1) check("R4 busy held", int'(busy), 1);
            if (cycles > 20) begin
                check("R4 watchdog", cycles, N + 1);
                break;
            end
        end
        start = 1'b0;
        check("R4 latency", cycles, N + 1);
        check("R4 busy low at done", int'(busy), 0);
        if (b == 0) begin
            eq = (1 << N) - 1;
            er = a;
        end else begin
            eq = a / b;
            er = a % b;
        end
        check(b == 0 ? "R7 quotient" : (inject ? "R6 quotient" : "R2 quotient"), int'(quotient), eq);
        check(b == 0 ? "R7 remainder" : (inject ? "R6 remainder" : "R3 remainder"), int'(remainder), er);
        check("R7 div_zero", int'(div_zero), (b == 0) ? 1 : 0);
        hq = quotient;
        hr = remainder;
        dividend = N'(a + 3);
        divisor = N'(b + 5);
        @(negedge clk);
        check("R5 done one cycle", int'(done), 0);
        check("R8 quotient held", int'(quotient), int'(hq));
        check("R8 remainder held", int'(remainder), int'(hr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 div_zero", int'(div_zero), 0);
        check("R1 quotient", int'(quotient), 0);
        check("R1 remainder", int'(remainder), 0);
        rst_n = 1'b1;
        // Worked case: 11 / 4 -> 2 remainder 3 (R2, R3)
        run(11, 4, 1'b0);
        for (int a = 0; a < (1 << N); a++) begin
            for (int b = 0; b < (1 << N); b++) begin
                run(a, b, 1'b0);
            end
        end
        // R6: mid-run start and operand changes
        run(13, 3, 1'b1);
        run(15, 1, 1'b1);
        run(7, 0, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule